// File: doc/BRIEF.md
# Programmable Countdown Timer

The block is a single down-counter that software sets up through seven word-wide registers on a simple 32-bit bus. A tick-enable input sets the counting rate. A prescaler divides that input by 1, 16 or 256, and each divided tick lowers the count by one while the timer is enabled. When a tick arrives at a count of zero, the counter either reloads or stops, depending on the mode, and it sets a raw interrupt flag.

Three modes are available. Periodic mode reloads the programmed value. Free-running mode wraps to the full-scale value of the selected width (16 or 32 bits). One-shot mode parks the counter at zero. Two separate write ports exist for the reload value: one also restarts the count at once, the other only takes effect at the next reload. The level interrupt output is the raw flag gated by an enable bit. Software can read both the raw flag and the masked flag.

Bus writes take effect at the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from the address.

Top module: `countdown_timer`

## Requirements
- R1: After reset the control register reads 0x20, the count, the stored reload value and the raw flag read 0, and `irq` is low.
- R2: Address bits [4:2] select a register. 0 is immediate load, 1 is current count, 2 is control, 3 is flag clear, 4 is raw flag, 5 is masked flag and 6 is background load. Index 7 reads 0 and writes to it change nothing. Writes to index 1 change nothing.
- R3: Control bit 0 selects one-shot, bit 1 selects 32-bit width, bits 3:2 select the prescaler, bit 5 enables the interrupt, bit 6 selects periodic and bit 7 enables counting. Bits 7:0 read back as written, and higher bits read 0.
- R4: A write to index 0 stores the reload value and sets the count to it at the same edge. A write to index 6 stores the reload value and leaves the count alone. Both indices read back the stored value.
- R5: While bit 7 is set, each prescaled tick lowers a nonzero count by one. With bit 7 clear the count does not move.
- R6: Prescaler code 00 passes every tick, 01 passes every 16th, 10 every 256th and 11 every tick. Any control write restarts the division.
- R7: In periodic mode a tick at count 0 reloads the stored value (truncated to the width) and sets the raw flag, so a load of N expires after N+1 ticks.
- R8: With periodic and one-shot clear, a tick at count 0 reloads 0xFFFF in 16-bit width or 0xFFFFFFFF in 32-bit width and sets the raw flag.
- R9: In one-shot mode a tick at count 0 sets the raw flag once and the count stays at 0. No further flag is raised until index 0 or index 2 is written.
- R10: In 16-bit width only bits 15:0 count, the upper bits read 0, loaded values are truncated, and a control write that selects 16-bit width truncates the current count.
- R11: The raw flag is set by an expiry and cleared by a write of any value to index 3. If both happen at the same edge, the flag stays set.
- R12: `irq` and the masked read are the raw flag ANDed with control bit 5, so both are 0 whenever bit 5 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counting-rate tick, one per cycle when high |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_en |
| bus_addr | input | 5 | Byte address; bits [4:2] pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level interrupt |

## Verification
Some properties are checked on every cycle. The count holds when no tick and no write occur. The upper half stays zero in 16-bit width. An idle or one-shot-finished counter holds at zero. Free-running 32-bit wrap lands on all ones. The raw flag obeys the set, clear and hold rules. A control write restarts the prescaler. Other behaviour only shows in the bench scenarios: the exact tick counts of each divider, the N+1 expiry period across modes and widths, background versus immediate load, and the one-shot re-arm.

// File: rtl/cdt_pkg.sv
// Package: shared types for the countdown timer.
// Assumes: register index taken from byte-address bits [4:2].
package cdt_pkg;

    typedef enum logic [2:0] {
        IDX_LOAD   = 3'd0,
        IDX_VALUE  = 3'd1,
        IDX_CTRL   = 3'd2,
        IDX_ICLR   = 3'd3,
        IDX_RAW    = 3'd4,
        IDX_MASKED = 3'd5,
        IDX_BGLOAD = 3'd6,
        IDX_NONE   = 3'd7
    } reg_idx_t;

    // Control byte, bit 7 first.
    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] prescale;
        logic       wide;
        logic       oneshot;
    } ctrl_t;

    localparam logic [7:0] CTRL_RESET = 8'h20;

endpackage

// File: rtl/cdt_regs.sv
// Module: cdt_regs
// Register file and read mux of the countdown timer. Produces one-cycle
// write strobes for the counter and interrupt logic.
// Assumes: ADDR_W >= 5; read data is purely combinational from the address.
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count_val,
    input  logic              raw_flag,
    output logic [DATA_W-1:0] bus_rdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] reload_val,
    output logic              load_wr,
    output logic              ctrl_wr,
    output logic              clr_wr
);

    localparam int IDX_LSB = 2;
    localparam int CTRL_W  = $bits(ctrl_t);

    reg_idx_t idx;
    logic     wr_any;
    logic     bg_wr;
    logic     unused_addr;

    assign idx         = reg_idx_t'(bus_addr[IDX_LSB+2:IDX_LSB]);
    assign unused_addr = ^{bus_addr[IDX_LSB-1:0], bus_addr[ADDR_W-1:IDX_LSB]};
    assign wr_any      = bus_en && bus_we;
    assign load_wr     = wr_any && (idx == IDX_LOAD);
    assign bg_wr       = wr_any && (idx == IDX_BGLOAD);
    assign ctrl_wr     = wr_any && (idx == IDX_CTRL);
    assign clr_wr      = wr_any && (idx == IDX_ICLR);

    // Control and reload storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= ctrl_t'(CTRL_RESET);
            reload_val <= '0;
        end else begin
            if (ctrl_wr)
                ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (load_wr || bg_wr)
                reload_val <= bus_wdata;
        end
    end

    // Read data selection.
    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_LOAD, IDX_BGLOAD: bus_rdata = reload_val;
            IDX_VALUE:            bus_rdata = count_val;
            IDX_CTRL:             bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
            IDX_RAW:              bus_rdata = {{(DATA_W-1){1'b0}}, raw_flag};
            IDX_MASKED:           bus_rdata = {{(DATA_W-1){1'b0}}, raw_flag && ctrl.irq_en};
            default:              bus_rdata = '0;
        endcase
    end

    a_r3_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (ctrl == ctrl_t'($past(bus_wdata[CTRL_W-1:0]))));

    a_r2_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(ctrl));

endmodule

// File: rtl/cdt_prescale.sv
// Module: cdt_prescale
// Divides the tick-enable input by 1, 2**SHIFT_A or 2**SHIFT_B.
// Assumes: restart has priority and clears the phase; code 11 divides by 1.
module cdt_prescale #(
    parameter int SHIFT_A = 4,
    parameter int SHIFT_B = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick_en,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       pulse
);

    localparam int PW = SHIFT_B;
    localparam logic [PW-1:0] LIM_A = PW'((1 << SHIFT_A) - 1);
    localparam logic [PW-1:0] LIM_B = '1;

    logic [PW-1:0] phase;
    logic [PW-1:0] limit;
    logic          adv;

    // Terminal phase for the selected ratio.
    always_comb begin
        unique case (sel)
            2'b01:   limit = LIM_A;
            2'b10:   limit = LIM_B;
            default: limit = '0;
        endcase
    end

    assign adv   = run && tick_en;
    assign pulse = adv && (phase == limit);

    // Phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase <= '0;
        else if (adv)
            phase <= (phase == limit) ? '0 : phase + 1'b1;
    end

    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !restart) |=> $stable(phase));

endmodule

// File: rtl/cdt_counter.sv
// Module: cdt_counter
// Down-counter with immediate load, width truncation and the three
// expiry behaviours (periodic reload, full-scale wrap, one-shot stop).
// Assumes: load and control writes never coincide (distinct addresses).
module cdt_counter #(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load_wr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_wide,
    input  logic              wide,
    input  logic              periodic,
    input  logic              oneshot,
    input  logic [DATA_W-1:0] reload_val,
    output logic [DATA_W-1:0] count,
    output logic              expire
);

    localparam logic [DATA_W-1:0] MASK_FULL = '1;
    localparam logic [DATA_W-1:0] MASK_HALF = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic [DATA_W-1:0] mask_now;
    logic [DATA_W-1:0] mask_new;
    logic              done;

    assign mask_now = wide    ? MASK_FULL : MASK_HALF;
    assign mask_new = wr_wide ? MASK_FULL : MASK_HALF;
    assign expire   = step && !done && (count == '0);

    // Count update: writes first, then expiry, then plain decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            done  <= 1'b0;
        end else if (load_wr) begin
            count <= wdata & mask_now;
            done  <= 1'b0;
        end else if (ctrl_wr) begin
            count <= count & mask_new;
            done  <= 1'b0;
        end else if (expire) begin
            if (oneshot)
                done <= 1'b1;
            else if (periodic)
                count <= reload_val & mask_now;
            else
                count <= mask_now;
        end else if (step && !done) begin
            count <= count - 1'b1;
        end
    end

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load_wr && !ctrl_wr) |=> $stable(count));

    a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> (count[DATA_W-1:HALF_W] == '0));

    a_r9_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load_wr && !ctrl_wr) |=> (count == '0 && !expire));

    a_r8_wrap_full: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !load_wr && !ctrl_wr && !oneshot && !periodic && wide) |=> (count == MASK_FULL));

endmodule

// File: rtl/cdt_irq.sv
// Module: cdt_irq
// Raw interrupt flag with set-over-clear priority and masked level output.
// Assumes: expire and clear are single-cycle strobes.
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_wr,
    input  logic irq_en,
    output logic raw,
    output logic irq
);

    // Raw flag: expiry wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw <= 1'b0;
        else if (expire)
            raw <= 1'b1;
        else if (clr_wr)
            raw <= 1'b0;
    end

    assign irq = raw && irq_en;

    a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw);

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !expire) |=> !raw);

    a_r11_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr_wr) |=> raw);

endmodule

// File: rtl/countdown_timer.sv
// Module: countdown_timer
// Top of the countdown timer: register file, prescaler, counter, interrupt.
// Assumes: single clock, synchronous active-low reset, word registers.
module countdown_timer
    import cdt_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int HALF_W  = 16,
    parameter int ADDR_W  = 5,
    parameter int SHIFT_A = 4,
    parameter int SHIFT_B = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [DATA_W-1:0] reload_val;
    logic [DATA_W-1:0] count;
    logic              load_wr;
    logic              ctrl_wr;
    logic              clr_wr;
    logic              step;
    logic              expire;
    logic              raw;
    ctrl_t             wr_ctrl;

    assign wr_ctrl = ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);

    cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count_val  (count),
        .raw_flag   (raw),
        .bus_rdata  (bus_rdata),
        .ctrl       (ctrl),
        .reload_val (reload_val),
        .load_wr    (load_wr),
        .ctrl_wr    (ctrl_wr),
        .clr_wr     (clr_wr)
    );

    cdt_prescale #(.SHIFT_A(SHIFT_A), .SHIFT_B(SHIFT_B)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl.run),
        .tick_en (tick_en),
        .restart (ctrl_wr),
        .sel     (ctrl.prescale),
        .pulse   (step)
    );

    cdt_counter #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load_wr    (load_wr),
        .ctrl_wr    (ctrl_wr),
        .wdata      (bus_wdata),
        .wr_wide    (wr_ctrl.wide),
        .wide       (ctrl.wide),
        .periodic   (ctrl.periodic),
        .oneshot    (ctrl.oneshot),
        .reload_val (reload_val),
        .count      (count),
        .expire     (expire)
    );

    cdt_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .clr_wr (clr_wr),
        .irq_en (ctrl.irq_en),
        .raw    (raw),
        .irq    (irq)
    );

    a_r12_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw && ctrl.irq_en));

endmodule

// File: tb/countdown_timer_test.sv
// Bench for countdown_timer: mode/width/load sweeps with an arithmetic model.
module countdown_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    countdown_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1;
        bus_addr = 5'(idx << 2); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        bus_addr = 5'(idx << 2);
        #1;
        v = bus_rdata;
    endtask

    task automatic ticks(input int k);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (k) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v, v2, m, mask, ctl;
        logic        r;
        logic [31:0] loads [4];
        loads[0] = 32'd0; loads[1] = 32'd1; loads[2] = 32'd3; loads[3] = 32'h0001_0002;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(2, v); check("R1 ctrl", v, 32'h20);
        rd(0, v); check("R1 load", v, 0);
        rd(1, v); check("R1 count", v, 0);
        rd(4, v); check("R1 raw", v, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R3: control read-back
        wr(2, 32'hABCD_0013); rd(2, v); check("R3 ctrl upper bits", v, 32'h13);
        wr(2, 32'h5B);        rd(2, v); check("R3 ctrl readback", v, 32'h5B);

        // R5 R7 R8 R10 R11 R12: sweep mode x width x load x ticks
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 2; s++)
                for (int li = 0; li < 4; li++)
                    for (int k = 0; k < 7; k++) begin
                        mask = (s != 0) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                        m = loads[li] & mask;
                        r = 1'b0;
                        for (int t = 0; t < k; t++) begin
                            if (m == 0) begin
                                r = 1'b1;
                                m = (p != 0) ? (loads[li] & mask) : mask;
                            end else m = m - 1;
                        end
                        ctl = 32'hA0 | (32'(p) << 6) | (32'(s) << 1);
                        wr(2, 0); wr(3, 0);
                        if (s != 0) wr(2, 32'h02);
                        wr(0, loads[li]);
                        wr(2, ctl);
                        ticks(k);
                        rd(1, v); check(p != 0 ? "R7 R10 periodic count" : "R8 R10 free count", v, m);
                        rd(4, v); check("R11 raw after ticks", v, {31'd0, r});
                        rd(5, v); check("R12 masked", v, {31'd0, r});
                        check("R12 irq", {31'd0, irq}, {31'd0, r});
                    end

        // R6: prescaler ratios
        wr(2, 0); wr(0, 5); wr(2, 32'hE6);
        ticks(15); rd(1, v); check("R6 div16 before", v, 5);
        ticks(1);  rd(1, v); check("R6 div16 at 16", v, 4);
        wr(0, 5); wr(2, 32'hEA);
        ticks(255); rd(1, v); check("R6 div256 before", v, 5);
        ticks(1);   rd(1, v); check("R6 div256 at 256", v, 4);
        wr(0, 5); wr(2, 32'hEE);
        ticks(1); rd(1, v); check("R6 code 11 divides by 1", v, 4);
        // R6: control write restarts division
        wr(0, 5); wr(2, 32'hE6);
        ticks(10); wr(2, 32'hE6); ticks(10);
        rd(1, v); check("R6 restart on ctrl write", v, 5);
        ticks(6); rd(1, v); check("R6 restart then 16", v, 4);

        // R5: disabled counter holds
        wr(2, 32'h62); wr(0, 7); ticks(20);
        rd(1, v); check("R5 disabled hold", v, 7);

        // R9: one-shot
        wr(2, 0); wr(3, 0); wr(0, 2); wr(2, 32'hA3);
        ticks(3);
        rd(1, v); check("R9 oneshot count", v, 0);
        rd(4, v); check("R9 oneshot flag", v, 1);
        wr(3, 0); ticks(5);
        rd(4, v); check("R9 no second flag", v, 0);
        rd(1, v); check("R9 parked at zero", v, 0);
        wr(0, 1); ticks(2);
        rd(4, v); check("R9 rearm by load", v, 1);

        // R4: background load
        wr(2, 0); wr(3, 0); wr(0, 3); wr(2, 32'hE2); wr(6, 9);
        rd(1, v); check("R4 bg keeps count", v, 3);
        rd(0, v); check("R4 load reads stored", v, 9);
        rd(6, v); check("R4 bg reads stored", v, 9);
        ticks(4);
        rd(1, v); check("R4 bg used at reload", v, 9);
        rd(4, v); check("R7 expiry flag", v, 1);

        // R2: ignored writes and unmapped index
        rd(1, v2); wr(1, 32'hDEAD_BEEF);
        rd(1, v); check("R2 value write ignored", v, v2);
        wr(7, 32'hFFFF_FFFF);
        rd(7, v); check("R2 index 7 reads 0", v, 0);
        rd(2, v); check("R2 index 7 ctrl intact", v, 32'hE2);
        rd(0, v); check("R2 index 7 load intact", v, 9);
        rd(1, v); check("R2 index 7 count intact", v, v2);
        rd(4, v); check("R2 index 7 raw intact", v, 1);

        // R12: mask off
        wr(2, 32'h42);
        rd(4, v); check("R12 raw with mask off", v, 1);
        rd(5, v); check("R12 masked off", v, 0);
        check("R12 irq masked off", {31'd0, irq}, 0);

        // R10: switching to 16-bit truncates count
        wr(2, 32'h02); wr(0, 32'h1234_5678); wr(2, 32'h00);
        rd(1, v); check("R10 truncate on ctrl", v, 32'h5678);

        // R11: clear and expiry at the same edge
        wr(2, 0); wr(3, 0); wr(0, 0); wr(2, 32'hE2);
        tick_en = 1'b1;
        wr(3, 0);
        tick_en = 1'b0;
        rd(4, v); check("R11 set wins over clear", v, 1);
        wr(3, 0); rd(4, v); check("R11 clear", v, 0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule